// File: doc/BRIEF.md
# Seven-to-One Parallel Display Serializer

The block takes one 28-bit parallel display word per pixel clock and spreads it over four serial data lanes, each lane sending seven bits per pixel period at seven times the pixel rate. A fifth lane sends a fixed seven-bit framing pattern in step with the data, so a receiver can find the word boundary. The word usually carries three 8-bit colour channels plus line-sync, frame-sync and data-enable bits. The block treats the word as opaque and only fixes which bit goes to which lane and slot.

Input capture is done on the pixel clock's rising or falling edge, chosen by a pin. Captured words pass through a pixel-domain holding register. A load strobe in the bit-clock domain moves each word into the lane shift registers once per pixel period. The seven-times bit clock is an input, and its rising edges line up with the pixel clock's rising edges. The bit domain finds the pixel boundary from a toggle flag that it samples half a bit period after the pixel edge. An active-low power-down input silences all five lanes, clears the shifters and lets output restart only at a word boundary.

Top module: `lane_serializer`

## Requirements
- R1: Lane L carries input bits [7L+6:7L], most significant first. Over one pixel period, lane 0 sends bit 6 down to bit 0, and lane 3 sends bit 27 down to bit 21.
- R2: While powered up, every captured word is sent exactly once. Consecutive words follow each other with no idle bit periods. Load strobes are exactly seven bit clocks apart.
- R3: The framing lane sends 1100011, first bit first, in the same seven bit periods as the data word it frames.
- R4: With edge_sel_i = 1, the word present at the pixel clock's rising edge is captured. The value present at the falling edge is ignored.
- R5: With edge_sel_i = 0, the word present at the pixel clock's falling edge is captured. The value present at the rising edge is ignored.
- R6: Take rising edge n as the capturing rising edge, or the rising edge just before a capturing falling edge. The word's first bit drives the lanes from one bit clock after rising edge n+1. Its last bit drives the lanes in the bit period that starts at rising edge n+2.
- R7: While pwr_ni is low, all four data lanes and the framing lane are low, and the shift registers are cleared.
- R8: After pwr_ni rises, all lanes stay low until the next load strobe. A release during pixel period r yields a first complete word that ends at rising edge r+2.
- R9: While rst_ni is low, all lanes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix_i | input | 1 | Pixel clock |
| clk_bit_i | input | 1 | Bit clock, seven times the pixel clock, rising edges aligned with pixel rising edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ni | input | 1 | Power-down, active low |
| edge_sel_i | input | 1 | 1: capture on the rising pixel edge, 0: on the falling edge |
| word_i | input | 28 | Parallel input word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Serial framing lane |

## Verification
The bench builds the block with its default parameters: four lanes of seven bits and the 1100011 framing pattern. A walking one over all 28 input positions then reaches every lane and every bit slot, which pins down the R1 mapping and the MSB-first order. Each capture mode is run after its own reset. A decoy value is placed on the edge that should be ignored, so capturing on the wrong edge corrupts the data. One power-down is released in the middle of a pixel period, which brings the quiet gap before the next load boundary within reach of the checks.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_SLICE = 7;
  localparam logic [DEF_SLICE-1:0] DEF_CLK_PAT = 7'b1100011;
endpackage

// File: rtl/ls_capture.sv
module ls_capture #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk_pix_i,
  input  logic              rst_ni,
  input  logic              edge_sel_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              tgl_o
);
  logic [WORD_W-1:0] rise_q, fall_q, hold_q;
  logic              tgl_q;

  always_ff @(posedge clk_pix_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= word_i;
  end

  always_ff @(negedge clk_pix_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= word_i;
  end

  // both paths reach hold on the same rising edge, so latency is mode-independent
  always_ff @(posedge clk_pix_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      hold_q <= edge_sel_i ? rise_q : fall_q;
      tgl_q  <= ~tgl_q;
    end
  end

  assign hold_o = hold_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/ls_frame_sync.sv
module ls_frame_sync (
  input  logic clk_bit_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic load_o
);
  logic tgl_n_q, tgl_p_q;

  // half-bit sampling keeps clear of the shared rising edge
  always_ff @(negedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni) tgl_n_q <= 1'b0;
    else         tgl_n_q <= tgl_i;
  end

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni) tgl_p_q <= 1'b0;
    else         tgl_p_q <= tgl_n_q;
  end

  assign load_o = tgl_n_q ^ tgl_p_q;
endmodule

// File: rtl/ls_lane.sv
module ls_lane #(
  parameter int unsigned SLICE = 7
) (
  input  logic             clk_bit_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [SLICE-1:0] par_i,
  output logic             ser_o
);
  logic [SLICE-1:0] sh_q;

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (clr_i)  sh_q <= '0;
    else if (load_i) sh_q <= par_i;
    else             sh_q <= {sh_q[SLICE-2:0], 1'b0};
  end

  assign ser_o = sh_q[SLICE-1];
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import lane_ser_pkg::*;
#(
  parameter int unsigned      LANES   = DEF_LANES,
  parameter int unsigned      SLICE   = DEF_SLICE,
  parameter logic [SLICE-1:0] CLK_PAT = DEF_CLK_PAT
) (
  input  logic                   clk_pix_i,
  input  logic                   clk_bit_i,
  input  logic                   rst_ni,
  input  logic                   pwr_ni,
  input  logic                   edge_sel_i,
  input  logic [LANES*SLICE-1:0] word_i,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk_lane_o
);
  localparam int unsigned WORD_W = LANES * SLICE;

  logic [WORD_W-1:0] hold;
  logic              tgl, raw_load, load, clr;
  logic [LANES-1:0]  ser;
  logic              clk_ser;

  ls_capture #(.WORD_W(WORD_W)) u_capture (
    .clk_pix_i (clk_pix_i),
    .rst_ni    (rst_ni),
    .edge_sel_i(edge_sel_i),
    .word_i    (word_i),
    .hold_o    (hold),
    .tgl_o     (tgl)
  );

  ls_frame_sync u_sync (
    .clk_bit_i(clk_bit_i),
    .rst_ni   (rst_ni),
    .tgl_i    (tgl),
    .load_o   (raw_load)
  );

  assign clr  = ~pwr_ni;
  assign load = raw_load & pwr_ni;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ls_lane #(.SLICE(SLICE)) u_lane (
      .clk_bit_i(clk_bit_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .load_i   (load),
      .par_i    (hold[l*SLICE +: SLICE]),
      .ser_o    (ser[l])
    );
  end

  ls_lane #(.SLICE(SLICE)) u_clk_lane (
    .clk_bit_i(clk_bit_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .load_i   (load),
    .par_i    (CLK_PAT),
    .ser_o    (clk_ser)
  );

  // gate so lanes drop in the same cycle power-down asserts
  assign lane_o     = ser & {LANES{pwr_ni}};
  assign clk_lane_o = clk_ser & pwr_ni;
endmodule

// File: rtl/lane_serializer_chk.sv
module lane_serializer_chk #(
  parameter int unsigned      LANES   = 4,
  parameter int unsigned      SLICE   = 7,
  parameter logic [SLICE-1:0] CLK_PAT = 7'b1100011
) (
  input logic                   clk_bit_i,
  input logic                   rst_ni,
  input logic                   pwr_ni,
  input logic                   raw_load_i,
  input logic                   load_i,
  input logic [LANES*SLICE-1:0] hold_i,
  input logic [LANES-1:0]       lane_i,
  input logic                   clk_lane_i
);
  localparam int unsigned GW = $clog2(SLICE + 1);

  logic [LANES-1:0] msb_vec;
  logic [GW-1:0]    gap_q;
  logic             seen_q, quiet_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) msb_vec[l] = hold_i[l*SLICE + SLICE - 1];
  end

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (raw_load_i) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GW'(SLICE)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni)      quiet_q <= 1'b0;
    else if (!pwr_ni) quiet_q <= 1'b1;
    else if (load_i)  quiet_q <= 1'b0;
  end

  a_r1_msb_first: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    (load_i ##1 pwr_ni) |-> lane_i == $past(msb_vec));

  a_r2_load_spacing: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    (raw_load_i && seen_q) |-> gap_q == GW'(SLICE - 1));

  a_r3_frame_start: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    (load_i ##1 pwr_ni) |-> clk_lane_i == CLK_PAT[SLICE-1]);

  a_r7_pd_silent: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    !pwr_ni |=> (lane_i == '0 && !clk_lane_i));

  a_r8_quiet_until_boundary: assert property (@(posedge clk_bit_i) disable iff (!rst_ni)
    quiet_q |-> (lane_i == '0 && !clk_lane_i));
endmodule

bind lane_serializer lane_serializer_chk #(
  .LANES  (LANES),
  .SLICE  (SLICE),
  .CLK_PAT(CLK_PAT)
) u_chk (
  .clk_bit_i (clk_bit_i),
  .rst_ni    (rst_ni),
  .pwr_ni    (pwr_ni),
  .raw_load_i(raw_load),
  .load_i    (load),
  .hold_i    (hold),
  .lane_i    (lane_o),
  .clk_lane_i(clk_lane_o)
);

// File: tb/lane_serializer_bench.sv
module lane_serializer_bench;
  localparam int LANES = 4;
  localparam int SLICE = 7;
  localparam int W     = LANES * SLICE;
  localparam logic [SLICE-1:0] PAT = 7'b1100011;
  localparam int BIG   = 32'h7fff_ffff;

  logic clk_bit = 1'b0, clk_pix = 1'b0;
  logic rst_ni = 1'b0, pwr_ni = 1'b1, edge_sel = 1'b1;
  logic [W-1:0] word_i = '0;
  logic [LANES-1:0] lane_o;
  logic clk_lane_o;

  lane_serializer u_lane_serializer (
    .clk_pix_i (clk_pix),
    .clk_bit_i (clk_bit),
    .rst_ni    (rst_ni),
    .pwr_ni    (pwr_ni),
    .edge_sel_i(edge_sel),
    .word_i    (word_i),
    .lane_o    (lane_o),
    .clk_lane_o(clk_lane_o)
  );

  // 125 MHz bit clock, pixel clock at one seventh, rising edges coincide
  always #4 clk_bit = ~clk_bit;
  initial begin
    #4;
    forever begin
      clk_pix = 1'b1; #28;
      clk_pix = 1'b0; #28;
    end
  end

  int pc = 0;
  always @(posedge clk_pix) pc <= pc + 1;

  typedef struct {
    logic [W-1:0] data;
    int           tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  int mon_from = BIG, mon_to = BIG, first_pd_pc = -1;
  bit drop_ok = 1'b0, done = 1'b0;
  string data_req = "R1 R4";

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: deserialize on bit negedges, frame on the pattern
  logic [SLICE-1:0] win_clk = '0;
  logic [SLICE-1:0] win_d [LANES];
  logic [W-1:0]     got;
  exp_t             e;
  always @(negedge clk_bit) begin
    if (!rst_ni) begin
      win_clk = '0;
      for (int l = 0; l < LANES; l++) win_d[l] = '0;
    end else begin
      win_clk = {win_clk[SLICE-2:0], clk_lane_o};
      for (int l = 0; l < LANES; l++) win_d[l] = {win_d[l][SLICE-2:0], lane_o[l]};
      if (win_clk == PAT && (pc - 2) >= mon_from && (pc - 2) <= mon_to) begin
        for (int l = 0; l < LANES; l++) got[l*SLICE +: SLICE] = win_d[l];
        if (drop_ok) begin
          while (q.size() > 0 && q[0].tag < pc - 2) void'(q.pop_front());
          first_pd_pc = pc;
          drop_ok = 1'b0;
        end
        if (q.size() == 0) chk(1'b0, "R2", pc, 0);
        else begin
          e = q.pop_front();
          chk(e.tag == pc - 2, "R6", e.tag, pc - 2);
          chk(got == e.data, data_req, got, e.data);
        end
      end
    end
  end

  function automatic logic [W-1:0] pat_of(input int i);
    if (i < W)       return W'(1) << i;
    else if (i == W) return '1;
    else if (i == W + 1) return 28'h5555555;
    else if (i == W + 2) return 28'hAAAAAAA;
    else return W'($urandom);
  endfunction

  task automatic push(input logic [W-1:0] d, input int tag);
    q.push_back('{data: d, tag: tag});
    if (mon_from == BIG) mon_from = tag;
    mon_to = tag;
  endtask

  // rising capture: value set before rising edge, decoy over the falling edge
  task automatic drive_rise(input logic [W-1:0] d);
    @(negedge clk_pix); #2;
    word_i = d;
    push(d, pc + 1);
    @(posedge clk_pix); #2;
    word_i = ~d;
  endtask

  // falling capture: value set after rising edge, decoy over the next rising edge
  task automatic drive_fall(input logic [W-1:0] d);
    @(posedge clk_pix); #2;
    word_i = d;
    push(d, pc);
    @(negedge clk_pix); #2;
    word_i = ~d;
  endtask

  task automatic do_reset(input logic sel);
    rst_ni = 1'b0;
    edge_sel = sel;
    pwr_ni = 1'b1;
    q.delete();
    mon_from = BIG;
    mon_to = BIG;
    repeat (3) @(posedge clk_pix);
    @(negedge clk_bit);
    chk(lane_o == '0 && !clk_lane_o, "R9", {lane_o, clk_lane_o}, 0);
    @(negedge clk_pix); #5;
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk_pix);
    #20;
    chk(q.size() == 0, "R2", q.size(), 0);
    mon_from = BIG;
  endtask

  initial begin
    logic [SLICE-1:0] seen;
    int rel_pc;
    // rising-edge capture with a mid-run power-down
    data_req = "R1 R4";
    do_reset(1'b1);
    fork
      begin
        for (int i = 0; i < W + 6; i++) drive_rise(pat_of(i));
      end
      begin
        repeat (4) @(posedge clk_pix);
        @(negedge clk_bit);
        seen = '0;
        for (int b = 0; b < SLICE; b++) begin
          @(negedge clk_bit);
          seen = {seen[SLICE-2:0], clk_lane_o};
        end
        chk(seen == PAT, "R3", seen, PAT);
        @(posedge clk_pix); #10;
        drop_ok = 1'b1;
        pwr_ni = 1'b0;
        for (int b = 0; b < 2 * SLICE; b++) begin
          @(negedge clk_bit);
          chk(lane_o == '0 && !clk_lane_o, "R7", {lane_o, clk_lane_o}, 0);
        end
        @(negedge clk_pix); #3;
        rel_pc = pc;
        pwr_ni = 1'b1;
        @(negedge clk_bit);
        chk(lane_o == '0 && !clk_lane_o, "R8", {lane_o, clk_lane_o}, 0);
        @(posedge clk_pix);
        @(negedge clk_bit);
        chk(lane_o == '0 && !clk_lane_o, "R8", {lane_o, clk_lane_o}, 0);
        repeat (2) @(posedge clk_pix);
        #1;
        chk(first_pd_pc == rel_pc + 2, "R8", first_pd_pc, rel_pc + 2);
      end
    join
    finish_run();

    // falling-edge capture
    data_req = "R1 R5";
    do_reset(1'b0);
    for (int i = 0; i < W + 6; i++) drive_fall(pat_of((i * 5) % (W + 6)));
    finish_run();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule